// File: doc/BRIEF.md
# Configurable Line-Size Fill Controller

This block refills a cache after a miss. The cache stores 16-byte physical lines. A small setting makes a logical line of 16, 32 or 64 bytes by filling one, two or four adjacent physical lines. When a miss is accepted, the controller aligns the miss address down to the logical line size. It then fetches the physical lines in that span one by one, in ascending order, over a valid/ready request channel to a banked external memory. Adjacent 16-byte lines sit in successive banks. Each returned line is written into the cache arrays with its own index, tag and valid bit, so later lookups still work at 16-byte granularity.

Two strobes follow the fill. One marks the cycle in which the physical line holding the missed address is written, so the requester can take its word before the rest of the logical line arrives. The other marks the final write of the fill. The size setting can only be changed while the controller is idle.

Top module: `lfc_fill_ctrl`

## Requirements
- R1: After reset the controller is idle. `miss_ready_o` is 1, no memory request or cache write is raised, and the size setting is code 0 (16 bytes).
- R2: Size code 0, 1 and 2 select 16, 32 and 64 bytes, so one miss writes exactly 1, 2 or 4 physical lines. A write of code 3 is rejected and leaves the setting unchanged.
- R3: A size write is accepted only in a cycle where the controller is idle and no miss is being accepted. During a fill it has no effect on `cur_size_o` or on the number of lines filled.
- R4: The first requested address is the miss address with its low 4+code bits cleared. Each following request is 16 bytes higher. Every request address has bits [3:0] equal to zero.
- R5: `mem_req_bank_o` equals request address bits [5:4], so consecutive lines of a fill go to successive banks.
- R6: At most one memory transfer is outstanding. While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address hold. No new request is raised until the previous response has been written, and a request is never raised in a cycle with a cache write.
- R7: Each response is written with `cache_we_o`=1 and `cache_valid_o`=1. The index is the request address bits [9:4], the tag is bits [31:10], and the data is the response data.
- R8: `word_avail_o` pulses exactly once per miss, together with the write of the physical line that contains the miss address.
- R9: `done_o` pulses only together with the last write of a fill. The cycle after it, `miss_ready_o` is 1 again.
- R10: A miss is taken only while `miss_ready_o` is 1. `miss_ready_o` drops in the cycle after acceptance, and a miss presented during a fill is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Size setting write strobe |
| cfg_size_i | input | 2 | Size code: 0=16 B, 1=32 B, 2=64 B |
| cur_size_o | output | 2 | Size code currently in force |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | 32 | Byte address that missed |
| miss_ready_o | output | 1 | Controller idle, a miss can be taken |
| mem_req_valid_o | output | 1 | Memory line request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 32 | 16-byte aligned line address |
| mem_req_bank_o | output | 2 | Bank number of the requested line |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | 128 | Returned physical line |
| cache_we_o | output | 1 | Cache array write enable |
| cache_index_o | output | 6 | Physical line index to write |
| cache_tag_o | output | 22 | Tag to write |
| cache_data_o | output | 128 | Line data to write |
| cache_valid_o | output | 1 | Valid bit to write |
| word_avail_o | output | 1 | Line holding the missed word written |
| done_o | output | 1 | Last line of the fill written |

## Verification
The assertions assume that memory sends exactly one response for each accepted request, and only after it. They also assume that `mem_rsp_valid_i` stays low while no request is waiting for data. The bench memory model follows this rule. It holds `mem_req_ready_i` low for zero or one cycle, returns a single response after one to three cycles, and never answers unless a handshake took place first. It raises a stray miss and a size write only in the middle of a fill, when a response is outstanding, so these inputs can be seen to be ignored.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned LINE_OFF_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } fill_state_e;
endpackage

// File: rtl/lfc_size_reg.sv
module lfc_size_reg #(
  parameter int unsigned SIZE_W  = 2,
  parameter int unsigned MAX_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_i,
  input  logic              upd_i,
  input  logic [SIZE_W-1:0] code_i,
  output logic [SIZE_W-1:0] size_o
);
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] size_d;
  logic              legal;
  logic              size_en;

  always_comb begin
    legal   = ({1'b0, code_i} <= (SIZE_W+1)'(MAX_LOG));
    size_en = upd_i & idle_i & legal;
    size_d  = size_en ? code_i : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
    end else if (size_en) begin
      size_q <= size_d;
    end
  end

  assign size_o = size_q;
endmodule

// File: rtl/lfc_addr_seq.sv
module lfc_addr_seq #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SIZE_W  = 2,
  parameter int unsigned MAX_LOG = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load_i,
  input  logic                                   step_i,
  input  logic [ADDR_W-1:0]                      miss_addr_i,
  input  logic [SIZE_W-1:0]                      size_i,
  output logic [ADDR_W-lfc_pkg::LINE_OFF_W-1:0]  line_o,
  output logic                                   last_o,
  output logic                                   crit_o
);
  localparam int unsigned LA_W  = ADDR_W - lfc_pkg::LINE_OFF_W;
  localparam int unsigned CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [LA_W-1:0]  base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] crit_q, crit_d;
  logic [CNT_W-1:0] span_mask;
  logic [LA_W-1:0]  miss_line;

  assign miss_line = miss_addr_i[ADDR_W-1:lfc_pkg::LINE_OFF_W];

  // Mask of line-number bits covered by the logical line.
  generate
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
      assign span_mask[gi] = ({1'b0, size_i} > (SIZE_W+1)'(gi));
    end
  endgenerate

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    crit_d = crit_q;
    if (load_i) begin
      base_d = miss_line & ~{{(LA_W-CNT_W){1'b0}}, span_mask};
      cnt_d  = '0;
      last_d = span_mask;
      crit_d = miss_line[CNT_W-1:0] & span_mask;
    end else if (step_i) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      crit_q <= '0;
    end else if (load_i | step_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      crit_q <= crit_d;
    end
  end

  // Base is aligned, so the offset merges by OR with no carry chain.
  assign line_o = base_q | {{(LA_W-CNT_W){1'b0}}, cnt_q};
  assign last_o = (cnt_q == last_q);
  assign crit_o = (cnt_q == crit_q);
endmodule

// File: rtl/lfc_fsm.sv
module lfc_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_valid_i,
  input  logic                last_i,
  input  logic                req_ready_i,
  input  logic                rsp_valid_i,
  output lfc_pkg::fill_state_e state_o,
  output logic                load_o,
  output logic                step_o,
  output logic                cap_o
);
  import lfc_pkg::*;

  fill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (miss_valid_i) begin
          load_o  = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid_i) begin
          cap_o   = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (last_i) begin
          state_d = ST_IDLE;
        end else begin
          step_o  = 1'b1;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/lfc_fill_ctrl.sv
module lfc_fill_ctrl #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned SIZE_W  = 2,
  parameter int unsigned MAX_LOG = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_wr_i,
  input  logic [SIZE_W-1:0]                             cfg_size_i,
  output logic [SIZE_W-1:0]                             cur_size_o,
  input  logic                                          miss_valid_i,
  input  logic [ADDR_W-1:0]                             miss_addr_i,
  output logic                                          miss_ready_o,
  output logic                                          mem_req_valid_o,
  input  logic                                          mem_req_ready_i,
  output logic [ADDR_W-1:0]                             mem_req_addr_o,
  output logic [BANK_W-1:0]                             mem_req_bank_o,
  input  logic                                          mem_rsp_valid_i,
  input  logic [DATA_W-1:0]                             mem_rsp_data_i,
  output logic                                          cache_we_o,
  output logic [IDX_W-1:0]                              cache_index_o,
  output logic [ADDR_W-lfc_pkg::LINE_OFF_W-IDX_W-1:0]   cache_tag_o,
  output logic [DATA_W-1:0]                             cache_data_o,
  output logic                                          cache_valid_o,
  output logic                                          word_avail_o,
  output logic                                          done_o
);
  import lfc_pkg::*;

  localparam int unsigned LA_W = ADDR_W - LINE_OFF_W;

  fill_state_e       state;
  logic              load, step, cap;
  logic              last, crit;
  logic              idle;
  logic [LA_W-1:0]   line;
  logic [DATA_W-1:0] data_q;
  logic [SIZE_W-1:0] size;

  assign idle = (state == ST_IDLE);

  lfc_size_reg #(
    .SIZE_W  (SIZE_W),
    .MAX_LOG (MAX_LOG)
  ) u_size (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle_i (idle & ~miss_valid_i),
    .upd_i  (cfg_wr_i),
    .code_i (cfg_size_i),
    .size_o (size)
  );

  lfc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid_i (miss_valid_i),
    .last_i       (last),
    .req_ready_i  (mem_req_ready_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .state_o      (state),
    .load_o       (load),
    .step_o       (step),
    .cap_o        (cap)
  );

  lfc_addr_seq #(
    .ADDR_W  (ADDR_W),
    .SIZE_W  (SIZE_W),
    .MAX_LOG (MAX_LOG)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .step_i      (step),
    .miss_addr_i (miss_addr_i),
    .size_i      (size),
    .line_o      (line),
    .last_o      (last),
    .crit_o      (crit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (cap) begin
      data_q <= mem_rsp_data_i;
    end
  end

  assign cur_size_o      = size;
  assign miss_ready_o    = idle;
  assign mem_req_valid_o = (state == ST_REQ);
  assign mem_req_addr_o  = {line, {LINE_OFF_W{1'b0}}};
  assign mem_req_bank_o  = line[BANK_W-1:0];
  assign cache_we_o      = (state == ST_WRITE);
  assign cache_index_o   = line[IDX_W-1:0];
  assign cache_tag_o     = line[LA_W-1:IDX_W];
  assign cache_data_o    = data_q;
  assign cache_valid_o   = cache_we_o;
  assign word_avail_o    = cache_we_o & crit;
  assign done_o          = cache_we_o & last;
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SIZE_W  = 2,
  parameter int unsigned MAX_LOG = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic              cache_we_o,
  input logic              word_avail_o,
  input logic              done_o,
  input logic [SIZE_W-1:0] cur_size_o
);
  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cur_size_o} <= (SIZE_W+1)'(MAX_LOG)));

  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_ready_o |=> $stable(cur_size_o));

  p_req_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (mem_req_addr_o[3:0] == 4'd0));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  p_no_req_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid_o && cache_we_o));

  p_avail_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_avail_o |-> cache_we_o);

  p_done_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cache_we_o);

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> miss_ready_o);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ready_o && miss_valid_i) |=> !miss_ready_o);
endmodule

bind lfc_fill_ctrl lfc_checker #(
  .ADDR_W  (ADDR_W),
  .SIZE_W  (SIZE_W),
  .MAX_LOG (MAX_LOG)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_valid_i    (miss_valid_i),
  .miss_ready_o    (miss_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .cache_we_o      (cache_we_o),
  .word_avail_o    (word_avail_o),
  .done_o          (done_o),
  .cur_size_o      (cur_size_o)
);

// File: tb/sim_lfc_fill_ctrl.sv
module sim_lfc_fill_ctrl;
  logic         clk;
  logic         rst_n;
  logic         cfg_wr_i;
  logic [1:0]   cfg_size_i;
  logic [1:0]   cur_size_o;
  logic         miss_valid_i;
  logic [31:0]  miss_addr_i;
  logic         miss_ready_o;
  logic         mem_req_valid_o;
  logic         mem_req_ready_i;
  logic [31:0]  mem_req_addr_o;
  logic [1:0]   mem_req_bank_o;
  logic         mem_rsp_valid_i;
  logic [127:0] mem_rsp_data_i;
  logic         cache_we_o;
  logic [5:0]   cache_index_o;
  logic [21:0]  cache_tag_o;
  logic [127:0] cache_data_o;
  logic         cache_valid_o;
  logic         word_avail_o;
  logic         done_o;

  int n_cmp;
  int n_bad;
  int sz_exp;
  bit finished;

  lfc_fill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .cfg_size_i(cfg_size_i),
    .cur_size_o(cur_size_o), .miss_valid_i(miss_valid_i), .miss_addr_i(miss_addr_i),
    .miss_ready_o(miss_ready_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_bank_o(mem_req_bank_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .cache_we_o(cache_we_o),
    .cache_index_o(cache_index_o), .cache_tag_o(cache_tag_o),
    .cache_data_o(cache_data_o), .cache_valid_o(cache_valid_o),
    .word_avail_o(word_avail_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a, ~a, a ^ 32'h5A5A_C3C3, a + 32'h1357_9BDF};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Memory model: one transfer at a time, varying stall and latency.
  initial begin
    int rc;
    logic [31:0] a;
    rc = 0;
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid_o) begin
        a = mem_req_addr_o;
        chk(a[3:0] == 4'd0, "R4 request aligned", a, a & ~32'hF);
        chk(mem_req_bank_o == a[5:4], "R5 bank", mem_req_bank_o, a[5:4]);
        if (rc % 2 == 1) begin
          @(negedge clk);
          chk(mem_req_valid_o && mem_req_addr_o == a, "R6 request held",
              mem_req_addr_o, a);
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        repeat (rc % 3) @(negedge clk);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = pat(a);
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        rc++;
      end
    end
  end

  task automatic set_size(input logic [1:0] code);
    @(negedge clk);
    cfg_wr_i   = 1'b1;
    cfg_size_i = code;
    @(negedge clk);
    cfg_wr_i   = 1'b0;
    if (code <= 2) sz_exp = code;
    chk(cur_size_o == sz_exp[1:0], "R2 size setting", cur_size_o, sz_exp);
  endtask

  task automatic run_miss(input logic [31:0] a, input bit disturb);
    int n, k, avail, cyc;
    bit fin;
    logic [31:0] base, ea;
    n = 1 << sz_exp;
    base = a & ~((32'd16 << sz_exp) - 1);
    k = 0; avail = 0; cyc = 0; fin = 1'b0;
    miss_addr_i  = a;
    miss_valid_i = 1'b1;
    @(negedge clk);
    miss_valid_i = 1'b0;
    chk(miss_ready_o == 1'b0, "R10 busy after accept", miss_ready_o, 0);
    while (!fin && cyc < 400) begin
      if (cache_we_o) begin
        ea = base + 32'(16 * k);
        chk(k < n, "R2 line count", k, n - 1);
        chk(cache_index_o == ea[9:4], "R7 index", cache_index_o, ea[9:4]);
        chk(cache_tag_o == ea[31:10], "R7 tag", cache_tag_o, ea[31:10]);
        chk(cache_data_o == pat(ea), "R7 data/R4 address order", cache_data_o, pat(ea));
        chk(cache_valid_o == 1'b1, "R7 valid", cache_valid_o, 1);
        chk(word_avail_o == (ea == (a & ~32'hF)), "R8 word available",
            word_avail_o, (ea == (a & ~32'hF)));
        chk(done_o == (k == n - 1), "R9 done on last", done_o, (k == n - 1));
        if (word_avail_o) avail++;
        if (done_o) fin = 1'b1;
        k++;
      end else begin
        chk(!done_o && !word_avail_o, "R9 no stray strobe", {done_o, word_avail_o}, 0);
      end
      if (disturb && cyc == 2) begin
        cfg_wr_i     = 1'b1;
        cfg_size_i   = 2'd0;
        miss_valid_i = 1'b1;
        miss_addr_i  = a ^ 32'h0000_1000;
      end else if (disturb && cyc == 3) begin
        cfg_wr_i     = 1'b0;
        miss_valid_i = 1'b0;
        chk(cur_size_o == sz_exp[1:0], "R3 size frozen in fill", cur_size_o, sz_exp);
      end
      cyc++;
      if (!fin) @(negedge clk);
    end
    chk(k == n, "R2 lines per miss", k, n);
    chk(avail == 1, "R8 one availability pulse", avail, 1);
    @(negedge clk);
    chk(miss_ready_o == 1'b1, "R9 idle after done", miss_ready_o, 1);
    chk(!cache_we_o && !mem_req_valid_o, "R10 stray miss ignored",
        {cache_we_o, mem_req_valid_o}, 0);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; sz_exp = 0; finished = 1'b0;
    rst_n = 1'b0;
    cfg_wr_i = 1'b0; cfg_size_i = '0;
    miss_valid_i = 1'b0; miss_addr_i = '0;
    repeat (3) @(negedge clk);
    chk(miss_ready_o == 1'b1, "R1 ready at reset", miss_ready_o, 1);
    chk(!mem_req_valid_o && !cache_we_o, "R1 quiet at reset",
        {mem_req_valid_o, cache_we_o}, 0);
    chk(cur_size_o == 2'd0, "R1 size at reset", cur_size_o, 0);
    rst_n = 1'b1;
    set_size(2'd3);
    for (int s = 0; s < 3; s++) begin
      set_size(2'(s));
      for (int b = 0; b < 3; b++) begin
        for (int off = 0; off < 64; off += 4) begin
          logic [31:0] base;
          base = (b == 0) ? 32'h0000_0000 : (b == 1) ? 32'hDEAD_BEC0 : 32'hFFFF_FFC0;
          run_miss(base + 32'(off), 1'b0);
        end
      end
    end
    set_size(2'd2);
    run_miss(32'h0000_4A74, 1'b1);
    chk(cur_size_o == 2'd2, "R3 size after fill", cur_size_o, 2);
    set_size(2'd3);
    set_size(2'd1);
    run_miss(32'h1234_5678, 1'b1);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end
endmodule